// File: doc/BRIEF.md
# DMA Control Register Unit

This unit executes the DMA control group of a processor's instruction set. It takes the second byte of an instruction in that group and splits it into a selector and a register field. The selector is the low nibble, bits [3:0]. The register field is the high nibble, bits [7:4]. The unit keeps the state that a separate DMA engine needs: a 16-bit transfer address, a 16-bit transfer count, a 4-bit transfer mode, an enable bit and a 3-bit status/map field. It moves values between this state and the CPU register file through one combinational read port and one registered write port.

Word operations name a word register directly: the read or write index is the 4-bit field. Byte operations name a byte register. They always use the low byte of the word register at index `{0, field[3:1]}`, whichever byte the field named. The status store keeps an old defect: each status bit reaches the register file only where the matching bit of the inverted register field is 1.

Every change of state, every register-file write and the illegal flag appear one clock after the edge that accepts the instruction (`instr_valid` high). The transfer datapath itself sits outside this unit.

Top module: `dmactl_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the address, count, mode, enable and map outputs are zero, and `rf_wr_en` and `illegal_op` are low. Reset takes effect at once when asserted, and its release is synchronised over two clocks.
- R2: Selector 0 loads `dma_addr` from the word register at the field index. The new value shows on the clock after the instruction.
- R3: Selector 1 writes `dma_addr` to the word register at the field index. The write happens one clock later with `rf_wr_be` = 2'b11.
- R4: Selector 2 loads `dma_count` from the word register at the field index. Selector 3 writes `dma_count` to that register with `rf_wr_be` = 2'b11, one clock later.
- R5: Selector 4 sets `dma_mode` to the 4-bit register field itself.
- R6: Selector 5 sets `dma_mode` to bits [3:0] of word register `{0, field[3:1]}`. The low byte is used even when the field is odd, that is, when it names a high byte.
- R7: Selector 6 sets `dma_enable` and selector 7 clears it.
- R8: Selector 8 loads `dma_map` from bits [2:0] of word register `{0, field[3:1]}`.
- R9: Selector 9 writes to word register `{0, field[3:1]}` with `rf_wr_be` = 2'b01. The data is `{13'b0, dma_map & ~field[2:0]}`.
- R10: Selectors 10 to 15 pulse `illegal_op` for one clock. They leave all state unchanged and make no register-file write.
- R11: While `instr_valid` is low, no state changes, `rf_wr_en` stays low and `illegal_op` stays low, whatever `instr_byte` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction byte is valid this cycle |
| instr_byte | input | 8 | Bits [7:4] register field, bits [3:0] selector |
| rf_rd_idx | output | 4 | Register-file read index (combinational) |
| rf_rd_data | input | 16 | Register-file read data for `rf_rd_idx` |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_be | output | 2 | Byte lanes written (bit 0 = low byte) |
| rf_wr_data | output | 16 | Register-file write data |
| illegal_op | output | 1 | One-clock pulse for an undefined selector |
| dma_addr | output | 16 | DMA transfer address |
| dma_count | output | 16 | DMA transfer count |
| dma_mode | output | 4 | DMA transfer mode |
| dma_enable | output | 1 | DMA enable |
| dma_map | output | 3 | Status/map field |

## Verification
Every result of this unit is due on the clock after the instruction: register loads, the mode, enable and map updates, the write-port strobe with its data, and the illegal pulse. The read index is the only exception; it is combinational and is consumed in the same cycle. The bench drives each instruction for a single clock starting at a falling edge and samples at the next falling edge. That samples the single cycle in which the write port and the illegal flag are live, and the moment the updated state first shows. The bench's register file applies writes with nonblocking updates at the rising edge, so a read issued on that edge still sees the old value, as a real register file would.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

  typedef enum logic [3:0] {
    SEL_LD_ADDR = 4'd0,
    SEL_ST_ADDR = 4'd1,
    SEL_LD_CNT  = 4'd2,
    SEL_ST_CNT  = 4'd3,
    SEL_MODE_K  = 4'd4,
    SEL_MODE_R  = 4'd5,
    SEL_EN_SET  = 4'd6,
    SEL_EN_CLR  = 4'd7,
    SEL_MAP_LD  = 4'd8,
    SEL_MAP_ST  = 4'd9
  } sel_e;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_ADDR = 2'd1,
    WSRC_CNT  = 2'd2,
    WSRC_MAP  = 2'd3
  } wsrc_e;

  typedef struct packed {
    logic  addr_we;
    logic  cnt_we;
    logic  mode_we;
    logic  mode_from_reg;
    logic  en_set;
    logic  en_clr;
    logic  map_we;
    wsrc_e wsrc;
    logic  byte_reg;
    logic  illegal;
  } dec_t;

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode #(
  parameter int SEL_W  = 4,
  parameter int RIDX_W = 4
) (
  input  logic                  valid,
  input  logic [SEL_W-1:0]      sel,
  input  logic [RIDX_W-1:0]     ridx,
  output dmactl_pkg::dec_t      dec,
  output logic [RIDX_W-1:0]     rd_idx
);
  import dmactl_pkg::*;

  logic byte_sel;

  // Byte-register selectors, flagged whether or not valid is high
  always_comb begin
    byte_sel = 1'b0;
    case (sel)
      SEL_MODE_R, SEL_MAP_LD, SEL_MAP_ST: byte_sel = 1'b1;
      default:                            byte_sel = 1'b0;
    endcase
  end

  // Byte ops: word holding the named byte, low byte always used
  assign rd_idx = byte_sel ? {1'b0, ridx[RIDX_W-1:1]} : ridx;

  always_comb begin
    dec          = '0;
    dec.wsrc     = WSRC_NONE;
    dec.byte_reg = byte_sel;
    if (valid) begin
      case (sel)
        SEL_LD_ADDR: dec.addr_we = 1'b1;
        SEL_ST_ADDR: dec.wsrc    = WSRC_ADDR;
        SEL_LD_CNT:  dec.cnt_we  = 1'b1;
        SEL_ST_CNT:  dec.wsrc    = WSRC_CNT;
        SEL_MODE_K:  dec.mode_we = 1'b1;
        SEL_MODE_R: begin
          dec.mode_we       = 1'b1;
          dec.mode_from_reg = 1'b1;
        end
        SEL_EN_SET:  dec.en_set  = 1'b1;
        SEL_EN_CLR:  dec.en_clr  = 1'b1;
        SEL_MAP_LD:  dec.map_we  = 1'b1;
        SEL_MAP_ST:  dec.wsrc    = WSRC_MAP;
        default:     dec.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4,
  parameter int MAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              cnt_we,
  input  logic              mode_we,
  input  logic              mode_from_reg,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              map_we,
  input  logic [MODE_W-1:0] mode_k,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              en_q,
  output logic [MAP_W-1:0]  map_q
);

  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [MODE_W-1:0] mode_nxt;
  logic              en_we;
  logic              en_nxt;
  logic [MAP_W-1:0]  map_nxt;

  // Next-state values; the byte forms take the low lane only
  always_comb begin
    addr_nxt = rd_data[ADDR_W-1:0];
    cnt_nxt  = rd_data[CNT_W-1:0];
    mode_nxt = mode_from_reg ? rd_data[MODE_W-1:0] : mode_k;
    map_nxt  = rd_data[MAP_W-1:0];
    en_we    = en_set | en_clr;
    en_nxt   = en_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      map_q  <= '0;
    end else begin
      if (addr_we) addr_q <= addr_nxt;
      if (cnt_we)  cnt_q  <= cnt_nxt;
      if (mode_we) mode_q <= mode_nxt;
      if (en_we)   en_q   <= en_nxt;
      if (map_we)  map_q  <= map_nxt;
    end
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> addr_q == $past(rd_data[ADDR_W-1:0])); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q)); // R11
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_q); // R7
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !en_q); // R7
  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> map_q == $past(rd_data[MAP_W-1:0])); // R8

endmodule

// File: rtl/dmactl_wrport.sv
module dmactl_wrport #(
  parameter int RIDX_W = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int MAP_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dmactl_pkg::wsrc_e   wsrc,
  input  logic                byte_op,
  input  logic [RIDX_W-1:0]   idx_d,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [MAP_W-1:0]    map,
  input  logic [MAP_W-1:0]    map_mask,
  output logic                wr_en,
  output logic [RIDX_W-1:0]   wr_idx,
  output logic [DATA_W/8-1:0] wr_be,
  output logic [DATA_W-1:0]   wr_data
);
  import dmactl_pkg::*;

  localparam int BE_W = DATA_W / 8;

  logic              wr_en_nxt;
  logic [BE_W-1:0]   be_nxt;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    wr_en_nxt = (wsrc != WSRC_NONE);
    be_nxt    = byte_op ? BE_W'(1) : '1;
    case (wsrc)
      WSRC_ADDR: data_nxt = DATA_W'(addr);
      WSRC_CNT:  data_nxt = DATA_W'(cnt);
      // Kept defect: status bits pass only where the field bit is 0
      WSRC_MAP:  data_nxt = DATA_W'(map & ~map_mask);
      default:   data_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_be   <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= wr_en_nxt;
      if (wr_en_nxt) begin
        wr_idx  <= idx_d;
        wr_be   <= be_nxt;
        wr_data <= data_nxt;
      end
    end
  end

  AST_WR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_be == '1 || wr_be == BE_W'(1))); // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != '1) |-> wr_data[DATA_W-1:8] == '0); // R9

endmodule

// File: rtl/dmactl_unit.sv
module dmactl_unit #(
  parameter int SEL_W  = 4,
  parameter int RIDX_W = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4,
  parameter int MAP_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      instr_valid,
  input  logic [RIDX_W+SEL_W-1:0]   instr_byte,
  output logic [RIDX_W-1:0]         rf_rd_idx,
  input  logic [DATA_W-1:0]         rf_rd_data,
  output logic                      rf_wr_en,
  output logic [RIDX_W-1:0]         rf_wr_idx,
  output logic [DATA_W/8-1:0]       rf_wr_be,
  output logic [DATA_W-1:0]         rf_wr_data,
  output logic                      illegal_op,
  output logic [ADDR_W-1:0]         dma_addr,
  output logic [CNT_W-1:0]          dma_count,
  output logic [MODE_W-1:0]         dma_mode,
  output logic                      dma_enable,
  output logic [MAP_W-1:0]          dma_map
);
  import dmactl_pkg::*;

  localparam int INSTR_W = RIDX_W + SEL_W;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [SEL_W-1:0]  sel;
  logic [RIDX_W-1:0] ridx;
  logic [RIDX_W-1:0] rd_idx;
  dec_t              dec;
  logic              ill_q;

  // Reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign sel       = instr_byte[SEL_W-1:0];
  assign ridx      = instr_byte[INSTR_W-1:SEL_W];
  assign rf_rd_idx = rd_idx;

  dmactl_decode #(.SEL_W(SEL_W), .RIDX_W(RIDX_W)) u_decode (
    .valid  (instr_valid),
    .sel    (sel),
    .ridx   (ridx),
    .dec    (dec),
    .rd_idx (rd_idx)
  );

  dmactl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MODE_W(MODE_W), .MAP_W(MAP_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .addr_we       (dec.addr_we),
    .cnt_we        (dec.cnt_we),
    .mode_we       (dec.mode_we),
    .mode_from_reg (dec.mode_from_reg),
    .en_set        (dec.en_set),
    .en_clr        (dec.en_clr),
    .map_we        (dec.map_we),
    .mode_k        (MODE_W'(ridx)),
    .rd_data       (rf_rd_data),
    .addr_q        (dma_addr),
    .cnt_q         (dma_count),
    .mode_q        (dma_mode),
    .en_q          (dma_enable),
    .map_q         (dma_map)
  );

  dmactl_wrport #(
    .RIDX_W(RIDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .MAP_W(MAP_W)
  ) u_wrport (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wsrc     (dec.wsrc),
    .byte_op  (dec.byte_reg),
    .idx_d    (rd_idx),
    .addr     (dma_addr),
    .cnt      (dma_count),
    .map      (dma_map),
    .map_mask (ridx[MAP_W-1:0]),
    .wr_en    (rf_wr_en),
    .wr_idx   (rf_wr_idx),
    .wr_be    (rf_wr_be),
    .wr_data  (rf_wr_data)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ill_q <= 1'b0;
    else             ill_q <= dec.illegal;
  end
  assign illegal_op = ill_q;

  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    illegal_op |-> !rf_wr_en); // R10
  AST_ILL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_core_n)
    illegal_op |-> ($stable(dma_enable) && $stable(dma_addr) && $stable(dma_mode))); // R10
  AST_WR_NEEDS_INSTR: assert property (@(posedge clk) disable iff (!rst_core_n)
    rf_wr_en |-> $past(instr_valid)); // R11

endmodule

// File: tb/dmactl_unit_tb_top.sv
module dmactl_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [7:0]  instr_byte;
  logic [3:0]  rf_rd_idx;
  logic [15:0] rf_rd_data;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_idx;
  logic [1:0]  rf_wr_be;
  logic [15:0] rf_wr_data;
  logic        illegal_op;
  logic [15:0] dma_addr;
  logic [15:0] dma_count;
  logic [3:0]  dma_mode;
  logic        dma_enable;
  logic [2:0]  dma_map;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dmactl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_byte(instr_byte),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_be(rf_wr_be),
    .rf_wr_data(rf_wr_data), .illegal_op(illegal_op),
    .dma_addr(dma_addr), .dma_count(dma_count), .dma_mode(dma_mode),
    .dma_enable(dma_enable), .dma_map(dma_map)
  );

  // Register-file model: word i = {15-i, i, 3*i, i+5} nibbles
  logic [15:0] rf [16];
  assign rf_rd_data = rf[rf_rd_idx];
  initial begin
    for (int i = 0; i < 16; i++) rf[i] = {4'(15 - i), 4'(i), 4'(3 * i), 4'(i + 5)};
    forever begin
      @(posedge clk);
      if (rf_wr_en) begin
        if (rf_wr_be[0]) rf[rf_wr_idx][7:0]  <= rf_wr_data[7:0];
        if (rf_wr_be[1]) rf[rf_wr_idx][15:8] <= rf_wr_data[15:8];
      end
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_byte  = b;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    check_eq("R1", {tag, " addr"},   32'(dma_addr),   32'h0);
    check_eq("R1", {tag, " count"},  32'(dma_count),  32'h0);
    check_eq("R1", {tag, " mode"},   32'(dma_mode),   32'h0);
    check_eq("R1", {tag, " enable"}, 32'(dma_enable), 32'h0);
    check_eq("R1", {tag, " map"},    32'(dma_map),    32'h0);
    check_eq("R1", {tag, " wr_en"},  32'(rf_wr_en),   32'h0);
    check_eq("R1", {tag, " illegal"},32'(illegal_op), 32'h0);
  endtask

  // Kinds: 0 addr, 1 count, 2 mode const, 3 mode reg, 4 enable, 5 map,
  //        6 store addr, 7 store count, 8 store map, 9 illegal
  function automatic string req_of(input logic [3:0] kind);
    case (kind)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R3";
      4'd7: return "R4";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  // {instr, kind, expected value, expected write index, expected lanes}
  localparam int NV = 18;
  localparam logic [33:0] VEC [NV] = '{
    {8'h30, 4'd0, 16'hC398, 4'h0, 2'b00},
    {8'hB2, 4'd1, 16'h4B10, 4'h0, 2'b00},
    {8'h91, 4'd6, 16'hC398, 4'h9, 2'b11},
    {8'hE3, 4'd7, 16'h4B10, 4'hE, 2'b11},
    {8'h74, 4'd2, 16'h0007, 4'h0, 2'b00},
    {8'hD5, 4'd3, 16'h000B, 4'h0, 2'b00},
    {8'h25, 4'd3, 16'h0006, 4'h0, 2'b00},
    {8'h06, 4'd4, 16'h0001, 4'h0, 2'b00},
    {8'h07, 4'd4, 16'h0000, 4'h0, 2'b00},
    {8'h06, 4'd4, 16'h0001, 4'h0, 2'b00},
    {8'hF8, 4'd5, 16'h0004, 4'h0, 2'b00},
    {8'h09, 4'd8, 16'h0004, 4'h0, 2'b01},
    {8'h38, 4'd5, 16'h0006, 4'h0, 2'b00},
    {8'h59, 4'd8, 16'h0002, 4'h2, 2'b01},
    {8'hA9, 4'd8, 16'h0004, 4'h5, 2'b01},
    {8'h79, 4'd8, 16'h0000, 4'h3, 2'b01},
    {8'h0A, 4'd9, 16'h0000, 4'h0, 2'b00},
    {8'hFF, 4'd9, 16'h0000, 4'h0, 2'b00}
  };

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s_addr, s_cnt;
    logic [3:0]  s_mode;
    logic        s_en;
    logic [2:0]  s_map;
    rst_n       = 1'b1;
    instr_valid = 1'b0;
    instr_byte  = 8'h00;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("in reset");            // R1
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("after release");       // R1

    for (int k = 0; k < NV; k++) begin
      logic [33:0] v;
      logic [3:0]  kind;
      logic [15:0] exp;
      string       req;
      v    = VEC[k];
      kind = v[25:22];
      exp  = v[21:6];
      req  = req_of(kind);
      issue(v[33:26]);
      case (kind)
        4'd0: check_eq(req, "dma_addr", 32'(dma_addr), 32'(exp));
        4'd1: check_eq(req, "dma_count", 32'(dma_count), 32'(exp));
        4'd2, 4'd3: check_eq(req, "dma_mode", 32'(dma_mode), 32'(exp));
        4'd4: check_eq(req, "dma_enable", 32'(dma_enable), 32'(exp));
        4'd5: check_eq(req, "dma_map", 32'(dma_map), 32'(exp));
        4'd6, 4'd7, 4'd8: begin
          check_eq(req, "wr_en", 32'(rf_wr_en), 32'h1);
          check_eq(req, "wr_idx", 32'(rf_wr_idx), 32'(v[5:2]));
          check_eq(req, "wr_be", 32'(rf_wr_be), 32'(v[1:0]));
          check_eq(req, "wr_data", 32'(rf_wr_data), 32'(exp));
        end
        default: check_eq(req, "illegal_op", 32'(illegal_op), 32'h1);
      endcase
      if (kind < 4'd6 || kind == 4'd9)
        check_eq(req, "no write", 32'(rf_wr_en), 32'h0);
      if (kind != 4'd9)
        check_eq(req, "no illegal", 32'(illegal_op), 32'h0);
    end

    // R10: undefined selector 12 with a nonzero field leaves all state alone
    s_addr = dma_addr; s_cnt = dma_count; s_mode = dma_mode;
    s_en = dma_enable; s_map = dma_map;
    issue(8'h3C);
    check_eq("R10", "illegal pulse", 32'(illegal_op), 32'h1);
    check_eq("R10", "wr_en", 32'(rf_wr_en), 32'h0);
    check_eq("R10", "addr kept", 32'(dma_addr), 32'(s_addr));
    check_eq("R10", "count kept", 32'(dma_count), 32'(s_cnt));
    check_eq("R10", "mode kept", 32'(dma_mode), 32'(s_mode));
    check_eq("R10", "enable kept", 32'(dma_enable), 32'(s_en));
    check_eq("R10", "map kept", 32'(dma_map), 32'(s_map));
    @(negedge clk);
    check_eq("R10", "pulse one clock", 32'(illegal_op), 32'h0);

    // R11: instruction bytes with valid low have no effect
    @(negedge clk);
    instr_byte = 8'h40;   // would load address from word 4
    @(negedge clk);
    check_eq("R11", "addr held", 32'(dma_addr), 32'(s_addr));
    instr_byte = 8'h07;   // would clear enable
    @(negedge clk);
    check_eq("R11", "enable held", 32'(dma_enable), 32'(s_en));
    instr_byte = 8'h01;   // would store address
    @(negedge clk);
    check_eq("R11", "no write", 32'(rf_wr_en), 32'h0);
    instr_byte = 8'h0E;   // undefined selector
    @(negedge clk);
    check_eq("R11", "no illegal", 32'(illegal_op), 32'h0);
    check_eq("R11", "mode held", 32'(dma_mode), 32'(s_mode));

    // R1: reset in mid-run clears state at once
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("mid-run release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule